// File: doc/BRIEF.md
# Address-Stable Automatic Sleep Controller

This block models the automatic low-power behaviour of an asynchronous-read memory. It compares the incoming address with the address it saw one cycle earlier. Once the address has stayed the same for a configured number of cycles, the block asserts a sleep flag and drops the enable to the memory array. The threshold is the array access time plus an extra settling margin, both given in clock cycles.

While the block is asleep, the output register keeps the last word read, so a host can still read it. Any change of address wakes the block in the same cycle. The array enable comes back at once, and the output is refreshed when the array reports valid data for the new address. The chip-enable and output-enable pins only decide whether the data pins are driven. They play no part in entering or leaving sleep.

Top module: `addr_idle_sleep`

## Requirements
- R1: While rst_n is low: sleep is 0, arr_en is 1 and dout is all zeros.
- R2: With THRESH = ACCESS_CYC + MARGIN_CYC (default 6), sleep rises after the new address has been sampled unchanged on THRESH+1 consecutive rising edges. The first of those edges is the one that registers the new value. Sleep stays low after only THRESH of those edges.
- R3: When the address on the port differs from the address registered at the previous edge, sleep is 0 and arr_en is 1 in that same cycle, before the next clock edge.
- R4: While sleep is 1, dout does not change, even when arr_valid pulses with different data.
- R5: The levels and toggling of ce_n and oe_n have no effect on when sleep rises or falls.
- R6: dout loads arr_data on a rising edge only when arr_valid is 1, sleep is 0 and the address is unchanged in that cycle. A valid pulse that coincides with an address change is discarded.
- R7: dq_drive is 1 exactly when ce_n and oe_n are both 0, whatever the sleep state.
- R8: An address change part-way through the count restarts the full THRESH+1 edge window. Once asleep, the block stays asleep for any length of stable address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| arr_data | input | DW | Data word from the array |
| arr_valid | input | 1 | Array data is valid for the current address |
| sleep | output | 1 | Low-power state flag |
| arr_en | output | 1 | Array enable, low while asleep |
| dout | output | DW | Latched read data |
| dq_drive | output | 1 | Data pins are driven |

## Verification
Four things are checked on every cycle:
- Sleep never coexists with an address that moved since the last edge.
- A detected change always forces the block awake with the array enabled.
- The output holds through any cycle that starts asleep.
- Every output change can be traced to an accepted valid pulse.

The exact edge count at which sleep appears, the restart of that window by a mid-count change, and saturation over long idle stretches can only be shown by the bench's scenarios. The same applies to the independence from the enable pins and the rejection of a valid pulse that coincides with an address change, which need chosen stimulus to observe.

// File: rtl/addr_idle_sleep.sv
module addr_idle_sleep #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int ACCESS_CYC = 4,
  parameter int MARGIN_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_data,
  input  logic          arr_valid,
  output logic          sleep,
  output logic          arr_en,
  output logic [DW-1:0] dout,
  output logic          dq_drive
);
  localparam int THRESH = ACCESS_CYC + MARGIN_CYC;
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] idle_cnt;
  logic          addr_chg;
  logic          take;

  assign addr_chg = (addr != addr_q);
  assign sleep    = !addr_chg && (idle_cnt == LIMIT);
  assign arr_en   = !sleep;
  assign take     = arr_valid && arr_en && !addr_chg;
  assign dq_drive = !ce_n && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      idle_cnt <= '0;
    end else begin
      addr_q <= addr;
      if (addr_chg)
        idle_cnt <= '0;
      else if (idle_cnt != LIMIT)
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dout <= '0;
    else if (take)
      dout <= arr_data;
  end

  p_sleep_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (addr == $past(addr)));

  p_wake_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> (!sleep && arr_en));

  p_hold_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(dout));

  p_load_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(arr_valid && !sleep));
endmodule

// File: tb/test_addr_idle_sleep.sv
module test_addr_idle_sleep;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int THRESH = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, oe_n;
  logic [DW-1:0] arr_data;
  logic          arr_valid;
  logic          sleep, arr_en, dq_drive;
  logic [DW-1:0] dout;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  addr_idle_sleep #(.AW(AW), .DW(DW), .ACCESS_CYC(4), .MARGIN_CYC(2)) i_addr_idle_sleep (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .arr_data(arr_data), .arr_valid(arr_valid), .sleep(sleep),
    .arr_en(arr_en), .dout(dout), .dq_drive(dq_drive));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_entry(input string req, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input bit toggle);
    addr = a;
    for (int i = 1; i <= THRESH; i++) begin
      tick();
      if (toggle) begin
        ce_n = i[0];
        oe_n = i[1];
      end
      chk({req, " sleep low before window"}, {31'd0, sleep}, 32'd0);
      if (i == 2) begin
        arr_valid = 1'b1;
        arr_data  = d;
      end else begin
        arr_valid = 1'b0;
      end
    end
    tick();
    chk({req, " sleep at window end"}, {31'd0, sleep}, 32'd1);
    chk({req, " arr_en low asleep"}, {31'd0, arr_en}, 32'd0);
    chk("R6 data loaded", {16'd0, dout}, {16'd0, d});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_n = 1'b1;
    arr_data = '0; arr_valid = 1'b0;
    tick(); tick();
    chk("R1 sleep", {31'd0, sleep}, 32'd0);
    chk("R1 arr_en", {31'd0, arr_en}, 32'd1);
    chk("R1 dout", {16'd0, dout}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_entry();
    run_entry("R2", 16'h1234, 16'hA5A5, 1'b0);
  endtask

  task automatic t_hold();
    arr_valid = 1'b1;
    arr_data  = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 dout held", {16'd0, dout}, 32'hA5A5);
      chk("R4 still asleep", {31'd0, sleep}, 32'd1);
    end
    arr_valid = 1'b0;
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 4; i++) begin
      repeat (10) tick();
      chk("R8 saturated sleep", {31'd0, sleep}, 32'd1);
    end
  endtask

  task automatic t_wake();
    addr = 16'h1235;
    #1;
    chk("R3 sleep drops same cycle", {31'd0, sleep}, 32'd0);
    chk("R3 arr_en same cycle", {31'd0, arr_en}, 32'd1);
    chk("R6 dout kept until valid", {16'd0, dout}, 32'hA5A5);
    run_entry("R3", 16'h1235, 16'h5A5A, 1'b0);
  endtask

  task automatic t_valid_on_change();
    addr = 16'h2000;
    arr_valid = 1'b1;
    arr_data = 16'hDEAD;
    tick();
    chk("R6 valid with change dropped", {16'd0, dout}, 32'h5A5A);
    arr_data = 16'hBEEF;
    tick();
    chk("R6 valid after change taken", {16'd0, dout}, 32'hBEEF);
    arr_valid = 1'b0;
    repeat (THRESH + 2) tick();
    chk("R6 settle asleep", {31'd0, sleep}, 32'd1);
  endtask

  task automatic t_restart();
    addr = 16'h3000;
    repeat (4) tick();
    chk("R8 mid-count awake", {31'd0, sleep}, 32'd0);
    run_entry("R8", 16'h3001, 16'h1111, 1'b0);
  endtask

  task automatic t_ctrl();
    run_entry("R5", 16'h4000, 16'h2222, 1'b1);
    for (int i = 0; i < 4; i++) begin
      ce_n = i[0];
      oe_n = i[1];
      #1;
      chk("R7 dq_drive", {31'd0, dq_drive}, (i == 0) ? 32'd1 : 32'd0);
      chk("R5 sleep unaffected", {31'd0, sleep}, 32'd1);
    end
    addr = 16'h4001;
    ce_n = 1'b0; oe_n = 1'b0;
    #1;
    chk("R7 dq_drive awake", {31'd0, dq_drive}, 32'd1);
    chk("R5 wake with enables low", {31'd0, sleep}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_entry();
    t_hold();
    t_saturate();
    t_wake();
    t_valid_on_change();
    t_restart();
    t_ctrl();
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule